// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a write-back, write-allocate data cache. Its main array is direct mapped: every memory line has exactly one slot, chosen by the low bits of its block address. Lines displaced from that slot are not thrown away at once. They go into a small fully associative side store, which is searched in parallel when the main slot does not hold the requested line. Two hot lines that conflict on one slot can therefore alternate without any memory traffic.

A processor issues one word access at a time through a valid/ready request port. Each access ends in a single-cycle response that carries the read data and a two-bit outcome code. Only when both the main array and the side store miss does the block use its line-wide lower-memory port. That port is a request/acknowledge handshake. If the side store is full and the line it must drop is dirty, that line is written back before the new line is read.

Top module: `vcache_vb`

## Requirements
- R1: After reset, req_ready_o is 1, resp_valid_o and mem_req_o are 0, and every line in both stores is invalid, so the first access to any address misses.
- R2: The main slot is (word address >> OFF_W) mod 2^IDX_W. An access whose tag matches a valid main line responds with resp_kind_o = 0, and resp_valid_o is high in the second cycle after the acceptance edge.
- R3: A main miss that matches a valid side-store entry responds with resp_kind_o = 1, one cycle later than a main hit. The line moves into the main slot, and the valid line it displaces takes its place in the side store.
- R4: A miss in both stores responds with resp_kind_o = 2 after one line read on the memory port (mem_we_o = 0, mem_addr_o = word address >> OFF_W). The line is installed in the main slot, and the valid line it displaces is inserted in the side store.
- R5: The side store holds VICT_N (default 4) lines. Inserting into a full store drops its least recently inserted entry. If that entry is dirty, it is written to memory (mem_we_o = 1) before the fill read is issued.
- R6: A clean line that is dropped from the side store produces no memory write.
- R7: A write that hits in either store updates the word, marks the line dirty and produces no memory traffic. A write miss fetches the line and then merges the word into it.
- R8: resp_rdata_o returns the current value of the addressed word. For a write, that is the value just written.
- R9: req_ready_o is 0 from the cycle after an acceptance until the response cycle, and a request offered in that time is not taken.
- R10: Once raised, mem_req_o stays high, with mem_addr_o and mem_we_o unchanged, until the cycle in which mem_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request offered |
| req_ready_o | output | 1 | Block is idle and takes the request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| resp_valid_o | output | 1 | One-cycle response pulse |
| resp_rdata_o | output | DATA_W | Word value after the access |
| resp_kind_o | output | 2 | 0 main hit, 1 side-store hit, 2 miss |
| mem_req_o | output | 1 | Lower-memory request |
| mem_we_o | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr_o | output | ADDR_W-OFF_W | Block address of the line |
| mem_wdata_o | output | LINE_W | Line written back |
| mem_ack_i | input | 1 | Request completes in this cycle |
| mem_rdata_i | input | LINE_W | Line read, valid with mem_ack_i |

## Verification
A main hit must produce its response in exactly the second cycle after the acceptance edge, and a side-store hit in exactly the third. A miss must complete in the cycle after the last memory acknowledge. The bench drives each request on a falling edge and then counts falling edges until resp_valid_o rises. It checks that count against the outcome that a behavioural model predicts, and it checks on every intermediate edge that req_ready_o stays low. The memory model acknowledges after a fixed delay. It compares each write-back it receives with the write-back the model expected for that access, and any write-back the model did not expect is reported.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
  typedef enum logic [1:0] {
    KIND_MAIN = 2'd0,
    KIND_VICT = 2'd1,
    KIND_MISS = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_SWAP,
    ST_WBACK,
    ST_FILL
  } state_e;
endpackage

// File: rtl/vcache_main_array.sv
module vcache_main_array #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 11,
  parameter int LINE_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_dirty_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_data_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      dirty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/vcache_victim_store.sv
module vcache_victim_store #(
  parameter int N      = 4,
  parameter int BLK_W  = 14,
  parameter int LINE_W = 128,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  look_blk_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  hit_sel_o,
  output logic              hit_dirty_o,
  output logic [LINE_W-1:0] hit_data_o,
  output logic              full_o,
  output logic [BLK_W-1:0]  old_blk_o,
  output logic              old_dirty_o,
  output logic [LINE_W-1:0] old_data_o,
  input  logic              rm_en_i,
  input  logic [SEL_W-1:0]  rm_sel_i,
  input  logic              push_en_i,
  input  logic [BLK_W-1:0]  push_blk_i,
  input  logic              push_dirty_i,
  input  logic [LINE_W-1:0] push_data_i
);
  // entry 0 is the oldest insertion; entries [0, cnt_q) are live
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BLK_W-1:0]  blk_q  [N];
  logic [BLK_W-1:0]  blk_n  [N];
  logic [N-1:0]      dirty_q, dirty_n;
  logic [LINE_W-1:0] data_q [N];
  logic [LINE_W-1:0] data_n [N];
  logic [N-1:0]      match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = (CNT_W'(g) < cnt_q) && (blk_q[g] == look_blk_i);
  end

  always_comb begin
    hit_sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_sel_o = SEL_W'(i);
    end
  end

  assign hit_o       = |match;
  assign hit_dirty_o = dirty_q[hit_sel_o];
  assign hit_data_o  = data_q[hit_sel_o];
  assign full_o      = (cnt_q == CNT_W'(N));
  assign old_blk_o   = blk_q[0];
  assign old_dirty_o = dirty_q[0];
  assign old_data_o  = data_q[0];

  always_comb begin
    cnt_n   = cnt_q;
    blk_n   = blk_q;
    dirty_n = dirty_q;
    data_n  = data_q;
    if (rm_en_i) begin
      for (int i = 0; i < N - 1; i++) begin
        if (SEL_W'(i) >= rm_sel_i) begin
          blk_n[i]   = blk_q[i+1];
          dirty_n[i] = dirty_q[i+1];
          data_n[i]  = data_q[i+1];
        end
      end
      cnt_n = cnt_q - CNT_W'(1);
    end
    if (push_en_i) begin
      if (cnt_n == CNT_W'(N)) begin
        for (int i = 0; i < N - 1; i++) begin
          blk_n[i]   = blk_n[i+1];
          dirty_n[i] = dirty_n[i+1];
          data_n[i]  = data_n[i+1];
        end
        blk_n[N-1]   = push_blk_i;
        dirty_n[N-1] = push_dirty_i;
        data_n[N-1]  = push_data_i;
      end else begin
        for (int i = 0; i < N; i++) begin
          if (CNT_W'(i) == cnt_n) begin
            blk_n[i]   = push_blk_i;
            dirty_n[i] = push_dirty_i;
            data_n[i]  = push_data_i;
          end
        end
        cnt_n = cnt_n + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      dirty_q <= '0;
    end else begin
      cnt_q   <= cnt_n;
      dirty_q <= dirty_n;
    end
  end

  always_ff @(posedge clk_i) begin
    blk_q  <= blk_n;
    data_q <= data_n;
  end
endmodule

// File: rtl/vcache_vb.sv
module vcache_vb
  import vcache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 3,
  parameter int VICT_N = 4,
  localparam int WORDS  = 1 << OFF_W,
  localparam int LINE_W = WORDS * DATA_W,
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int TAG_W  = BLK_W - IDX_W,
  localparam int SEL_W  = (VICT_N > 1) ? $clog2(VICT_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic [1:0]        resp_kind_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BLK_W-1:0]  mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  state_e state_q, state_n;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [BLK_W-1:0] blk;
  assign off = addr_q[OFF_W-1:0];
  assign idx = addr_q[OFF_W +: IDX_W];
  assign tag = addr_q[ADDR_W-1 -: TAG_W];
  assign blk = addr_q[ADDR_W-1:OFF_W];

  logic              m_valid, m_dirty;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_data;
  logic              mw_en;
  logic [LINE_W-1:0] new_line;
  logic              new_dirty;

  logic              v_hit, v_hit_dirty, v_full, v_old_dirty;
  logic [SEL_W-1:0]  v_hit_sel;
  logic [LINE_W-1:0] v_hit_data, v_old_data;
  logic [BLK_W-1:0]  v_old_blk;
  logic              v_rm, v_push;

  logic  main_hit;
  logic  resp_fire;
  kind_e kind_n;
  logic [LINE_W-1:0] src_line;
  logic              src_dirty;
  logic [DATA_W-1:0] word_out;

  vcache_main_array #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .LINE_W(LINE_W)
  ) main_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (idx),
    .rd_valid_o(m_valid),
    .rd_dirty_o(m_dirty),
    .rd_tag_o  (m_tag),
    .rd_data_o (m_data),
    .wr_en_i   (mw_en),
    .wr_idx_i  (idx),
    .wr_dirty_i(new_dirty),
    .wr_tag_i  (tag),
    .wr_data_i (new_line)
  );

  vcache_victim_store #(
    .N     (VICT_N),
    .BLK_W (BLK_W),
    .LINE_W(LINE_W)
  ) vict_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_blk_i  (blk),
    .hit_o       (v_hit),
    .hit_sel_o   (v_hit_sel),
    .hit_dirty_o (v_hit_dirty),
    .hit_data_o  (v_hit_data),
    .full_o      (v_full),
    .old_blk_o   (v_old_blk),
    .old_dirty_o (v_old_dirty),
    .old_data_o  (v_old_data),
    .rm_en_i     (v_rm),
    .rm_sel_i    (v_hit_sel),
    .push_en_i   (v_push),
    .push_blk_i  ({m_tag, idx}),
    .push_dirty_i(m_dirty),
    .push_data_i (m_data)
  );

  assign main_hit = m_valid && (m_tag == tag);

  always_comb begin
    unique case (state_q)
      ST_SWAP: begin
        src_line  = v_hit_data;
        src_dirty = v_hit_dirty;
      end
      ST_FILL: begin
        src_line  = mem_rdata_i;
        src_dirty = 1'b0;
      end
      default: begin
        src_line  = m_data;
        src_dirty = m_dirty;
      end
    endcase
    new_line = src_line;
    if (we_q) new_line[int'(off)*DATA_W +: DATA_W] = wdata_q;
    new_dirty = src_dirty | we_q;
    word_out  = new_line[int'(off)*DATA_W +: DATA_W];
  end

  always_comb begin
    state_n   = state_q;
    mw_en     = 1'b0;
    v_rm      = 1'b0;
    v_push    = 1'b0;
    resp_fire = 1'b0;
    kind_n    = KIND_MISS;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    mem_addr_o = blk;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_n = ST_LOOKUP;
      ST_LOOKUP: begin
        if (main_hit) begin
          mw_en     = we_q;
          resp_fire = 1'b1;
          kind_n    = KIND_MAIN;
          state_n   = ST_IDLE;
        end else if (v_hit) begin
          state_n = ST_SWAP;
        end else if (m_valid && v_full && v_old_dirty) begin
          state_n = ST_WBACK;
        end else begin
          state_n = ST_FILL;
        end
      end
      ST_SWAP: begin
        mw_en     = 1'b1;
        v_rm      = 1'b1;
        v_push    = m_valid;
        resp_fire = 1'b1;
        kind_n    = KIND_VICT;
        state_n   = ST_IDLE;
      end
      ST_WBACK: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = v_old_blk;
        if (mem_ack_i) state_n = ST_FILL;
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          mw_en     = 1'b1;
          v_push    = m_valid;
          resp_fire = 1'b1;
          kind_n    = KIND_MISS;
          state_n   = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign mem_wdata_o = v_old_data;
  assign req_ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      we_q         <= 1'b0;
      wdata_q      <= '0;
      resp_valid_o <= 1'b0;
      resp_rdata_o <= '0;
      resp_kind_o  <= 2'd0;
    end else begin
      state_q      <= state_n;
      resp_valid_o <= resp_fire;
      if (state_q == ST_IDLE && req_valid_i) begin
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (resp_fire) begin
        resp_rdata_o <= word_out;
        resp_kind_o  <= kind_n;
      end
    end
  end
endmodule

// File: rtl/vcache_vb_chk.sv
module vcache_vb_chk #(
  parameter int BLK_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             resp_valid_o,
  input logic [1:0]       resp_kind_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [BLK_W-1:0] mem_addr_o,
  input logic             mem_ack_i
);
  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  // R9
  idle_at_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> req_ready_o);

  // R2
  kind_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> resp_kind_o != 2'd3);

  // R7
  hit_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_kind_o != 2'd2 |-> !$past(mem_req_o));

  // R4
  miss_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_kind_o == 2'd2 |-> $past(mem_ack_i && mem_req_o && !mem_we_o));

  // R5
  fill_after_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> mem_req_o && !mem_we_o);
endmodule

bind vcache_vb vcache_vb_chk #(.BLK_W(BLK_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .resp_valid_o(resp_valid_o),
  .resp_kind_o (resp_kind_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/vcache_vb_tb.sv
module vcache_vb_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 2;
  localparam int IDX_W  = 3;
  localparam int VICT_N = 4;
  localparam int WORDS  = 1 << OFF_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_W = WORDS * DATA_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready, resp_valid;
  logic [DATA_W-1:0] resp_rdata;
  logic [1:0]        resp_kind;
  logic              mem_req, mem_we;
  logic [BLK_W-1:0]  mem_addr;
  logic [LINE_W-1:0] mem_wdata;
  logic              mem_ack = 1'b0;
  logic [LINE_W-1:0] mem_rdata = '0;

  vcache_vb #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .VICT_N(VICT_N)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata), .resp_kind_o(resp_kind),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] init_line(input int b);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < WORDS; w++) l[w*DATA_W +: DATA_W] = {16'hC0DE, 16'(b * WORDS + w)};
    return l;
  endfunction

  // lower memory seen by the DUT
  logic [LINE_W-1:0] phys [int];
  // behavioural model state
  logic [LINE_W-1:0] ref_mem [int];
  bit                r_valid [LINES];
  bit                r_dirty [LINES];
  int                r_tag   [LINES];
  logic [LINE_W-1:0] r_line  [LINES];
  int                vq_blk   [$];
  bit                vq_dirty [$];
  logic [LINE_W-1:0] vq_line  [$];

  bit                wb_pend = 1'b0;
  int                wb_blk;
  logic [LINE_W-1:0] wb_data;

  task automatic ref_access(input int addr, input bit we, input logic [DATA_W-1:0] wd,
                            output int kind, output logic [DATA_W-1:0] rd);
    int off = addr % WORDS;
    int b   = addr / WORDS;
    int idx = b % LINES;
    int tg  = b / LINES;
    int hit_j = -1;
    logic [LINE_W-1:0] line;
    bit dty;
    if (r_valid[idx] && r_tag[idx] == tg) begin
      kind = 0; line = r_line[idx]; dty = r_dirty[idx];
    end else begin
      foreach (vq_blk[j]) if (vq_blk[j] == b) hit_j = j;
      if (hit_j >= 0) begin
        kind = 1; line = vq_line[hit_j]; dty = vq_dirty[hit_j];
        vq_blk.delete(hit_j); vq_dirty.delete(hit_j); vq_line.delete(hit_j);
      end else begin
        kind = 2;
        if (r_valid[idx] && vq_blk.size() == VICT_N) begin
          if (vq_dirty[0]) begin
            wb_pend = 1'b1; wb_blk = vq_blk[0]; wb_data = vq_line[0];
            ref_mem[vq_blk[0]] = vq_line[0];
          end
          void'(vq_blk.pop_front()); void'(vq_dirty.pop_front()); void'(vq_line.pop_front());
        end
        line = ref_mem.exists(b) ? ref_mem[b] : init_line(b);
        dty = 1'b0;
      end
      if (r_valid[idx]) begin
        vq_blk.push_back(r_tag[idx] * LINES + idx);
        vq_dirty.push_back(r_dirty[idx]);
        vq_line.push_back(r_line[idx]);
      end
    end
    if (we) begin
      line[off*DATA_W +: DATA_W] = wd;
      dty = 1'b1;
    end
    rd = line[off*DATA_W +: DATA_W];
    r_valid[idx] = 1'b1; r_dirty[idx] = dty; r_tag[idx] = tg; r_line[idx] = line;
  endtask

  // lower-memory responder: acknowledge MEM_LAT cycles into a request
  int mcnt = 0;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mcnt = 0;
    end else if (rst_n && mem_req) begin
      mcnt++;
      if (mcnt == MEM_LAT) begin
        if (mem_we) begin
          // R5 / R6: every write-back must be one the model predicted
          chk(wb_pend, "R6", "unexpected write-back, block", LINE_W'(mem_addr), '0);
          if (wb_pend) begin
            chk(int'(mem_addr) == wb_blk, "R5", "write-back block", LINE_W'(mem_addr), LINE_W'(wb_blk));
            chk(mem_wdata == wb_data, "R5", "write-back data", mem_wdata, wb_data);
          end
          wb_pend = 1'b0;
          phys[int'(mem_addr)] = mem_wdata;
        end else begin
          mem_rdata = phys.exists(int'(mem_addr)) ? phys[int'(mem_addr)] : init_line(int'(mem_addr));
        end
        mem_ack = 1'b1;
      end
    end
  end

  task automatic access(input int addr, input bit we, input logic [DATA_W-1:0] wd);
    int kind;
    int n = 0;
    bit saw_mem = 1'b0;
    logic [DATA_W-1:0] exp_rd;
    ref_access(addr, we, wd, kind, exp_rd);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", LINE_W'(req_ready), 1);
    req_valid = 1'b1; req_we = we; req_addr = ADDR_W'(addr); req_wdata = wd;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
      if (resp_valid) break;
      if (req_ready) chk(1'b0, "R9", "ready while busy", LINE_W'(req_ready), 0);
      if (mem_req) saw_mem = 1'b1;
    end while (n < 400);
    chk(resp_valid == 1'b1, "R9", "response seen", LINE_W'(resp_valid), 1);
    chk(int'(resp_kind) == kind, kind == 0 ? "R2" : kind == 1 ? "R3" : "R4",
        "outcome code", LINE_W'(resp_kind), LINE_W'(kind));
    chk(resp_rdata == exp_rd, we ? "R7" : "R8", "word value", LINE_W'(resp_rdata), LINE_W'(exp_rd));
    if (kind == 0) chk(n == 2, "R2", "main hit latency", LINE_W'(n), 2);
    if (kind == 1) chk(n == 3, "R3", "side-store hit latency", LINE_W'(n), 3);
    if (kind != 2) chk(!saw_mem, "R7", "memory traffic on hit", LINE_W'(saw_mem), 0);
    chk(!wb_pend, "R5", "predicted write-back missing", LINE_W'(wb_pend), 0);
    wb_pend = 1'b0;
  endtask

  function automatic int mk(input int t, input int i, input int o);
    return (t * LINES + i) * WORDS + o;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_vec++; n_bad++;
      $display("FAIL R9 watchdog: cycles=%0d expected < %0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    int seed = 7;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "ready in reset", LINE_W'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1", "resp_valid in reset", LINE_W'(resp_valid), 0);
    chk(mem_req == 1'b0, "R1", "mem_req in reset", LINE_W'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !mem_req, "R1", "idle after reset", LINE_W'(req_ready), 1);

    access(mk(0, 1, 2), 0, '0);            // R1/R4 cold miss
    access(mk(0, 1, 2), 0, '0);            // R2 main hit
    access(mk(0, 1, 1), 1, 32'h1111_1111); // R7 write hit
    access(mk(0, 1, 1), 0, '0);            // R8 read back
    access(mk(1, 1, 0), 0, '0);            // R4 conflict miss, dirty line to side store
    access(mk(0, 1, 1), 0, '0);            // R3 swap back
    access(mk(1, 1, 3), 0, '0);            // R3 swap again
    for (int t = 2; t <= 6; t++) access(mk(t, 1, 0), 0, '0); // R5 dirty drop, R6 clean drop
    access(mk(0, 1, 1), 0, '0);            // R5 value survives in memory
    access(mk(7, 0, 2), 1, 32'hBEEF_0001); // R7 write miss
    access(mk(7, 0, 2), 0, '0);            // R7 merged word
    // R9: request offered while busy is not taken
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = ADDR_W'(mk(3, 5, 0));
    @(negedge clk);
    req_addr = ADDR_W'(mk(4, 5, 0));
    @(negedge clk);
    chk(req_ready == 1'b0, "R9", "ready while busy", LINE_W'(req_ready), 0);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    begin
      int k; logic [DATA_W-1:0] e;
      ref_access(mk(3, 5, 0), 0, '0, k, e);
      chk(resp_rdata == e, "R9", "first request served", LINE_W'(resp_rdata), LINE_W'(e));
      wb_pend = 1'b0;
    end
    // mixed traffic on two heavily conflicting slots
    for (int s = 0; s < 400; s++) begin
      seed = seed * 1103515245 + 12345;
      access(mk((seed >>> 8) & 7 % 6 + ((seed >>> 8) & 7) / 6 * 0, (seed >>> 12) & 1, (seed >>> 14) & 3),
             ((seed >>> 17) & 3) == 0, 32'(seed));
    end
    finish_run();
  end
endmodule